// File: doc/BRIEF.md
# PCI Configuration-Space Target Decoder

This block is the configuration-space responder of a 32-bit PCI target. It watches the shared address/data bus, the command/byte-enable lines, the device-select strobe and the FRAME/IRDY handshake. When an address phase carries a Type 0 configuration read or write addressed to this device, the block claims the cycle. It then picks one of 64 Dword slots from address bits [7:2] and completes exactly one data phase.

Slots 0 to 3 hold read-only identification words that are set by parameters. One slot, slot 4 by default, is a writable 32-bit scratch register that is updated one byte lane at a time. Every other slot is empty: writes to it are dropped and reads of it return zero, and the bus sees a normal completion in both cases. A master that tries to burst is disconnected after the first Dword. The 64-bit acknowledge output is never asserted.

The control path is one state machine:

| State | Meaning |
|-------|---------|
| ST_IDLE | Bus idle, looking for an address phase. |
| ST_DECODE | Claimed; the medium-timing wait cycle. |
| ST_XFER | The data phase: DEVSEL and TRDY are low, and STOP is also low while FRAME is still low. |
| ST_DISC | The Dword is done; the block holds DEVSEL and STOP low with TRDY high until the master lets go of the bus. |
| ST_TURN | One turnaround cycle with DEVSEL high. |
| ST_SKIP | The cycle is not for this block; it waits for the bus to go idle. |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| ST_IDLE | ST_DECODE | An address phase that meets all the hit conditions. |
| ST_IDLE | ST_SKIP | Any other address phase. |
| ST_DECODE | ST_XFER | Always, after one cycle. |
| ST_XFER | ST_TURN | IRDY is low and FRAME is high (single Dword). |
| ST_XFER | ST_DISC | IRDY is low and FRAME is low (burst attempt). |
| ST_DISC | ST_TURN | FRAME and IRDY are both high. |
| ST_TURN | ST_IDLE | Always. |
| ST_SKIP | ST_IDLE | FRAME and IRDY are both high. |

An address phase is a clock edge at which FRAME is sampled low after it was sampled high on the previous edge, while the machine is idle.

Top module: `cfg_target_decoder`

## Requirements
- R1: A cycle is claimed only if idsel is high at the address phase. With idsel low, devsel_n stays high for the whole cycle and nothing is written.
- R2: All target outputs are high (deasserted) after reset. For a claimed cycle, devsel_n and trdy_n go low one clock after the address-phase edge, so the master first samples them low on the second edge after the address phase (medium timing).
- R3: The slot index is ad_in[7:2] at the address phase. Address bits [31:8] do not affect which slot is selected.
- R4: A configuration write to the scratch slot (slot 4) updates byte lane i, bits [8i+7:8i], only when cbe_n[i] is 0 in the data phase. Lanes with cbe_n[i] equal to 1 keep their value.
- R5: Slots 0 to 3 read back their four parameter words. A write to any of them leaves the value unchanged.
- R6: Every slot other than 0 to 4 reads as 32'h0 and drops writes. The cycle still completes normally, with devsel_n and trdy_n low for one data phase.
- R7: ad_oe is high only in the data-phase cycle of a claimed read, when trdy_n is low, and ad_out then carries the selected slot's value. At all other times ad_out is zero.
- R8: If frame_n is still low while trdy_n is low, stop_n is also low. Only the first Dword is transferred. After that, devsel_n and stop_n stay low with trdy_n high until frame_n and irdy_n are both high.
- R9: ack64_n is high in every cycle.
- R10: Only command 4'b1010 (configuration read) and 4'b1011 (configuration write) on cbe_n at the address phase are claimed. Any other command is ignored even when idsel is high.
- R11: An address phase with ad_in[1:0] other than 2'b00 is not claimed.
- R12: After a completed cycle, devsel_n is high for one turnaround cycle. A new address phase after that is claimed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data as driven by the master |
| ad_out | output | 32 | Read data driven back onto the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| cbe_n | input | 4 | Command at the address phase, active-low byte enables in the data phase |
| idsel | input | 1 | Device select for configuration cycles |
| frame_n | input | 1 | Cycle framing from the master, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target disconnect request, active low |
| ack64_n | output | 1 | 64-bit acknowledge, held inactive |

## Verification
The bench builds the block with its default geometry: 64 slots, four read-only words and the scratch slot at index 4. It overrides the four identification words with distinct, non-trivial patterns and gives the scratch register a non-zero reset value. With those values, a wrong slot index, a lane mix-up or a write that leaks into a read-only slot shows up as a value mismatch instead of a match of zeros. Because the scratch slot sits right after the read-only words, the boundaries on both sides of the implemented range are exercised, as well as empty slots far from it.

// File: rtl/cfg_tgt_pkg.sv
package cfg_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_XFER,
        ST_DISC,
        ST_TURN,
        ST_SKIP
    } tgt_state_e;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_tgt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr_lo,
    input  logic [3:0]       cmd,
    input  logic             idsel,
    input  logic             capture,
    output logic             hit,
    output logic [IDX_W-1:0] idx_q,
    output logic             is_wr_q
);

    logic cmd_is_rd;
    logic cmd_is_wr;
    logic dword_aligned;

    always_comb begin
        cmd_is_rd     = (cmd == CMD_CFG_RD);
        cmd_is_wr     = (cmd == CMD_CFG_WR);
        dword_aligned = (addr_lo[1:0] == 2'b00);
        hit           = idsel && (cmd_is_rd || cmd_is_wr) && dword_aligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            is_wr_q <= 1'b0;
        end else if (capture) begin
            idx_q   <= addr_lo[IDX_W+1:2];
            is_wr_q <= cmd_is_wr;
        end
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int          DATA_W      = 32,
    parameter int          IDX_W       = 6,
    parameter int          SCRATCH_IDX = 4,
    parameter logic [31:0] ID_WORD0    = 32'h0000_0000,
    parameter logic [31:0] ID_WORD1    = 32'h0000_0000,
    parameter logic [31:0] ID_WORD2    = 32'h0000_0000,
    parameter logic [31:0] ID_WORD3    = 32'h0000_0000,
    parameter logic [31:0] SCRATCH_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W/8-1:0] be_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANES  = DATA_W / 8;
    localparam int NUM_RO = 4;
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(NUM_RO);
    localparam logic [IDX_W-1:0] SCR_SLOT = IDX_W'(SCRATCH_IDX);

    logic [DATA_W-1:0] scratch_q;
    logic              scr_sel;

    function automatic logic [DATA_W-1:0] ro_word(input logic [1:0] sel);
        logic [31:0] w;
        unique case (sel)
            2'd0: w = ID_WORD0;
            2'd1: w = ID_WORD1;
            2'd2: w = ID_WORD2;
            default: w = ID_WORD3;
        endcase
        return DATA_W'(w);
    endfunction

    assign scr_sel = (idx == SCR_SLOT);

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scratch_q[8*b +: 8] <= SCRATCH_RST[8*b +: 8];
                end else if (wr_en && scr_sel && !be_n[b]) begin
                    scratch_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    endgenerate

    always_comb begin
        if (idx < RO_LIMIT) begin
            rdata = ro_word(idx[1:0]);
        end else if (scr_sel) begin
            rdata = scratch_q;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/cfg_target_fsm.sv
module cfg_target_fsm
    import cfg_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic hit,
    input  logic is_wr,
    output logic capture,
    output logic wr_en,
    output logic devsel_n,
    output logic trdy_n,
    output logic stop_n,
    output logic ad_oe
);

    tgt_state_e state_q;
    tgt_state_e state_d;
    logic       frame_prev_q;
    logic       addr_phase;

    assign addr_phase = (state_q == ST_IDLE) && !frame_n && frame_prev_q;
    assign capture    = addr_phase && hit;
    assign wr_en      = (state_q == ST_XFER) && !irdy_n && is_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            frame_prev_q <= 1'b1;
        end else begin
            state_q      <= state_d;
            frame_prev_q <= frame_n;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_phase) begin
                    state_d = hit ? ST_DECODE : ST_SKIP;
                end
            end
            ST_DECODE: state_d = ST_XFER;
            ST_XFER: begin
                if (!irdy_n) begin
                    state_d = frame_n ? ST_TURN : ST_DISC;
                end
            end
            ST_DISC: begin
                if (frame_n && irdy_n) begin
                    state_d = ST_TURN;
                end
            end
            ST_TURN: state_d = ST_IDLE;
            ST_SKIP: begin
                if (frame_n && irdy_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        ad_oe    = 1'b0;
        unique case (state_q)
            ST_XFER: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                stop_n   = frame_n;
                ad_oe    = !is_wr;
            end
            ST_DISC: begin
                devsel_n = 1'b0;
                stop_n   = 1'b0;
            end
            ST_IDLE, ST_DECODE, ST_TURN, ST_SKIP: begin
                devsel_n = 1'b1;
            end
            default: devsel_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_target_decoder.sv
module cfg_target_decoder #(
    parameter int          DATA_W      = 32,
    parameter int          IDX_W       = 6,
    parameter int          SCRATCH_IDX = 4,
    parameter logic [31:0] ID_WORD0    = 32'h1234_ABCD,
    parameter logic [31:0] ID_WORD1    = 32'h0200_0000,
    parameter logic [31:0] ID_WORD2    = 32'h0B80_0001,
    parameter logic [31:0] ID_WORD3    = 32'h0000_0010,
    parameter logic [31:0] SCRATCH_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [3:0]        cbe_n,
    input  logic              idsel,
    input  logic              frame_n,
    input  logic              irdy_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              ack64_n
);

    logic             hit;
    logic             capture;
    logic             wr_en;
    logic             is_wr;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rdata;
    logic             oe_int;

    cfg_addr_decode #(
        .IDX_W (IDX_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_lo (ad_in[7:0]),
        .cmd     (cbe_n),
        .idsel   (idsel),
        .capture (capture),
        .hit     (hit),
        .idx_q   (idx),
        .is_wr_q (is_wr)
    );

    cfg_target_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .hit      (hit),
        .is_wr    (is_wr),
        .capture  (capture),
        .wr_en    (wr_en),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .ad_oe    (oe_int)
    );

    cfg_regfile #(
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .SCRATCH_IDX (SCRATCH_IDX),
        .ID_WORD0    (ID_WORD0),
        .ID_WORD1    (ID_WORD1),
        .ID_WORD2    (ID_WORD2),
        .ID_WORD3    (ID_WORD3),
        .SCRATCH_RST (SCRATCH_RST)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .idx   (idx),
        .be_n  (cbe_n),
        .wdata (ad_in),
        .rdata (rdata)
    );

    assign ad_oe   = oe_int;
    assign ad_out  = oe_int ? rdata : '0;
    assign ack64_n = 1'b1;

endmodule

// File: rtl/cfg_target_decoder_chk.sv
module cfg_target_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       irdy_n,
    input logic       idsel,
    input logic       devsel_n,
    input logic       trdy_n,
    input logic       stop_n,
    input logic       ack64_n,
    input logic       ad_oe
);

    // R1
    no_claim_without_idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && !idsel) |=> devsel_n ##1 devsel_n);

    // R2
    medium_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> ($past(idsel, 2) && !$past(frame_n, 2)));

    // R2
    trdy_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R7
    oe_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !trdy_n);

    // R8
    stop_on_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !frame_n) |-> !stop_n);

    // R8
    single_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> trdy_n);

    // R9
    no_ack64_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !devsel_n |-> ack64_n);

    // R12
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> devsel_n);

endmodule

bind cfg_target_decoder cfg_target_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .idsel    (idsel),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ack64_n  (ack64_n),
    .ad_oe    (ad_oe)
);

// File: tb/cfg_target_decoder_test.sv
`timescale 1ns/1ps
module cfg_target_decoder_test;

    localparam logic [31:0] W0  = 32'h8086_5A17;
    localparam logic [31:0] W1  = 32'h0290_0146;
    localparam logic [31:0] W2  = 32'h0B40_00C3;
    localparam logic [31:0] W3  = 32'h0000_7E10;
    localparam logic [31:0] SRST = 32'hC001_D00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [3:0]  cbe_n = 4'hF;
    logic        idsel = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        devsel_n, trdy_n, stop_n, ack64_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfg_target_decoder #(
        .ID_WORD0 (W0), .ID_WORD1 (W1), .ID_WORD2 (W2), .ID_WORD3 (W3),
        .SCRATCH_RST (SRST)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ad_in (ad_in), .ad_out (ad_out),
        .ad_oe (ad_oe), .cbe_n (cbe_n), .idsel (idsel), .frame_n (frame_n),
        .irdy_n (irdy_n), .devsel_n (devsel_n), .trdy_n (trdy_n),
        .stop_n (stop_n), .ack64_n (ack64_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural reference model of the bus response
    int          m_mode;   // 0 idle, 1 claimed, 2 ignored, 3 turnaround
    int          m_age;
    bit          m_done;
    bit          m_wr;
    int          m_idx;
    bit          m_prevf;
    logic [31:0] m_scr;

    function automatic logic [31:0] model_read(input int slot);
        case (slot)
            0: return W0;
            1: return W1;
            2: return W2;
            3: return W3;
            4: return m_scr;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_done = 0; m_wr = 0; m_idx = 0;
            m_prevf = 1; m_scr = SRST;
        end else begin
            if (m_mode == 0) begin
                if (!frame_n && m_prevf) begin
                    if (idsel && (cbe_n == 4'b1010 || cbe_n == 4'b1011) && ad_in[1:0] == 2'b00) begin
                        m_mode = 1; m_age = 0; m_done = 0;
                        m_idx = int'(ad_in[7:2]); m_wr = (cbe_n == 4'b1011);
                    end else begin
                        m_mode = 2;
                    end
                end
            end else if (m_mode == 1) begin
                if (m_age >= 1 && !m_done && !irdy_n) begin
                    if (m_wr && m_idx == 4)
                        for (int b = 0; b < 4; b++)
                            if (!cbe_n[b]) m_scr[8*b +: 8] = ad_in[8*b +: 8];
                    m_done = 1;
                    if (frame_n) m_mode = 3;
                end else if (m_done && frame_n && irdy_n) begin
                    m_mode = 3;
                end
                m_age++;
            end else if (m_mode == 3) begin
                m_mode = 0;
            end else if (m_mode == 2) begin
                if (frame_n && irdy_n) m_mode = 0;
            end
            m_prevf = frame_n;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            logic e_dev, e_trdy, e_stop, e_oe;
            logic [31:0] e_ad;
            e_dev  = (m_mode == 1) && (m_age >= 1);
            e_trdy = e_dev && !m_done;
            e_stop = e_dev && (m_done || !frame_n);
            e_oe   = e_trdy && !m_wr;
            e_ad   = e_oe ? model_read(m_idx) : 32'h0;
            chk("R2 devsel_n", 32'(devsel_n), 32'(!e_dev));
            chk("R2 trdy_n", 32'(trdy_n), 32'(!e_trdy));
            chk("R8 stop_n", 32'(stop_n), 32'(!e_stop));
            chk("R9 ack64_n", 32'(ack64_n), 32'h1);
            chk("R7 ad_oe", 32'(ad_oe), 32'(e_oe));
            chk("R7 ad_out", ad_out, e_ad);
        end
    end

    task automatic txn(input bit sel, input logic [3:0] cmd, input logic [31:0] addr,
                       input logic [3:0] be, input logic [31:0] d0, input logic [31:0] d1,
                       input int ndw, output logic [31:0] rd, output bit claimed,
                       output bit saw_stop);
        rd = '0; claimed = 0; saw_stop = 0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; idsel = sel; cbe_n = cmd; ad_in = addr;
        @(negedge clk);
        idsel = 1'b0; cbe_n = be; ad_in = d0; irdy_n = 1'b0;
        frame_n = (ndw > 1) ? 1'b0 : 1'b1;
        @(negedge clk);
        if (!devsel_n && !trdy_n) begin
            claimed = 1; rd = ad_out; saw_stop = !stop_n;
            @(negedge clk);
            if (ndw > 1) begin
                ad_in = d1; frame_n = 1'b1;
                if (!stop_n) saw_stop = 1;
                @(negedge clk);
            end
            irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        end else begin
            @(negedge clk);
            if (!devsel_n) claimed = 1;
            @(negedge clk);
            if (!devsel_n) claimed = 1;
            frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_rd(input int slot, output logic [31:0] v, output bit cl);
        bit st;
        txn(1'b1, 4'b1010, 32'(slot) << 2, 4'h0, 32'h0, 32'h0, 1, v, cl, st);
    endtask

    task automatic cfg_wr(input int slot, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] v; bit cl, st;
        txn(1'b1, 4'b1011, 32'(slot) << 2, be, d, 32'h0, 1, v, cl, st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit cl, st;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 reset devsel_n", 32'(devsel_n), 32'h1);
        chk("R2 reset trdy_n", 32'(trdy_n), 32'h1);
        chk("R2 reset stop_n", 32'(stop_n), 32'h1);
        chk("R7 reset ad_oe", 32'(ad_oe), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5, R3: identification words
        cfg_rd(0, v, cl); chk("R5 slot0", v, W0);
        cfg_rd(1, v, cl); chk("R5 slot1", v, W1);
        cfg_rd(2, v, cl); chk("R5 slot2", v, W2);
        cfg_rd(3, v, cl); chk("R5 slot3", v, W3);
        cfg_rd(4, v, cl); chk("R4 scratch reset", v, SRST);

        // R4 full and partial writes
        cfg_wr(4, 4'h0, 32'h1234_5678);
        cfg_rd(4, v, cl); chk("R4 full write", v, 32'h1234_5678);
        cfg_wr(4, 4'b0101, 32'hAABB_CCDD);
        cfg_rd(4, v, cl); chk("R4 lanes 1,3", v, 32'hAA34_CC78);
        cfg_wr(4, 4'b1110, 32'h0000_0099);
        cfg_rd(4, v, cl); chk("R4 lane 0", v, 32'hAA34_CC99);

        // R5 read-only ignores writes
        cfg_wr(1, 4'h0, 32'hFFFF_FFFF);
        cfg_rd(1, v, cl); chk("R5 slot1 after write", v, W1);

        // R6 unimplemented slots
        cfg_wr(20, 4'h0, 32'hDEAD_0001);
        cfg_rd(20, v, cl); chk("R6 slot20 reads zero", v, 32'h0);
        chk("R6 slot20 claimed", 32'(cl), 32'h1);
        cfg_wr(5, 4'h0, 32'h5555_AAAA);
        cfg_rd(5, v, cl); chk("R6 slot5 reads zero", v, 32'h0);
        cfg_rd(63, v, cl); chk("R6 slot63 reads zero", v, 32'h0);
        cfg_rd(4, v, cl); chk("R6 scratch untouched", v, 32'hAA34_CC99);

        // R1 idsel low
        txn(1'b0, 4'b1011, 32'h10, 4'h0, 32'h0BAD_0BAD, 32'h0, 1, v, cl, st);
        chk("R1 not claimed", 32'(cl), 32'h0);
        cfg_rd(4, v, cl); chk("R1 scratch unchanged", v, 32'hAA34_CC99);

        // R10 other command
        txn(1'b1, 4'b0111, 32'h10, 4'h0, 32'h0BAD_0BAD, 32'h0, 1, v, cl, st);
        chk("R10 mem write ignored", 32'(cl), 32'h0);
        txn(1'b1, 4'b0110, 32'h10, 4'h0, 32'h0, 32'h0, 1, v, cl, st);
        chk("R10 mem read ignored", 32'(cl), 32'h0);
        cfg_rd(4, v, cl); chk("R10 scratch unchanged", v, 32'hAA34_CC99);

        // R11 misaligned type field
        txn(1'b1, 4'b1011, 32'h11, 4'h0, 32'h0BAD_0BAD, 32'h0, 1, v, cl, st);
        chk("R11 ad[1:0]=01 ignored", 32'(cl), 32'h0);
        cfg_rd(4, v, cl); chk("R11 scratch unchanged", v, 32'hAA34_CC99);

        // R8 burst disconnect
        txn(1'b1, 4'b1011, 32'h10, 4'h0, 32'h0BAD_F00D, 32'hDEAD_BEEF, 2, v, cl, st);
        chk("R8 stop seen", 32'(st), 32'h1);
        cfg_rd(4, v, cl); chk("R8 only first dword", v, 32'h0BAD_F00D);
        txn(1'b1, 4'b1010, 32'h0, 4'h0, 32'h0, 32'h0, 2, v, cl, st);
        chk("R8 read burst stop", 32'(st), 32'h1);
        chk("R8 read burst data", v, W0);

        // R3 upper address bits ignored
        txn(1'b1, 4'b1010, 32'hFF00_0010, 4'h0, 32'h0, 32'h0, 1, v, cl, st);
        chk("R3 upper bits", v, 32'h0BAD_F00D);
        txn(1'b1, 4'b1010, 32'h0000_010C, 4'h0, 32'h0, 32'h0, 1, v, cl, st);
        chk("R3 bit8 ignored", v, W3);

        // R12 back-to-back cycles after turnaround
        cfg_rd(2, v, cl); chk("R12 first", v, W2);
        cfg_rd(2, v, cl); chk("R12 second claimed", 32'(cl), 32'h1);
        chk("R9 ack64 idle", 32'(ack64_n), 32'h1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule